// File: doc/BRIEF.md
# Machine Status Word with Coprocessor Trap Decision

This block keeps the processor's 16-bit machine status word. Only the four low bits carry meaning: a one-way protected-mode enable, a coprocessor-monitor bit, a coprocessor-emulate bit and a task-switched bit. The twelve upper bits always read as one. Software writes the word with a load strobe and reads it back on `word_q`. The load works in real-address mode as well as in protected mode. The task-switch logic sets the task-switched bit through its own strobe. A dedicated clear strobe removes it.

The instruction decoder also drives this block. For every coprocessor-related instruction it raises a one-cycle "wait instruction" or "escape instruction" indication. The block then decides whether that instruction must take exception 7, the coprocessor-not-available trap, and answers with a registered one-cycle pulse. An escape instruction traps when the emulate bit or the task-switched bit is set. A wait instruction traps only when the monitor bit and the task-switched bit are both set.

All pins are plain control and status signals with no handshake. Every strobe acts in the cycle it is sampled high, and the block cannot apply back-pressure.

Top module: `mode_word_trap`

## Requirements
- R1: After reset `word_q` reads 16'hFFF0, `prot_mode` is 0 and `trap7` is 0.
- R2: When `load_en` is high at a clock edge, bits 1 (monitor), 2 (emulate) and 3 (task switched) of `load_data` appear in the same positions of `word_q` from the next cycle on.
- R3: Bit 0 (protected enable) is set by a load whose data bit 0 is 1. A later load with data bit 0 equal to 0 leaves it at 1, and only reset clears it.
- R4: Bits 15 to 4 of `word_q` always read 1, whatever data is loaded.
- R5: `ts_set` sets bit 3 and `ts_clr` clears it, both effective in the next cycle. When several of them act in the same cycle, `ts_set` wins over `ts_clr`, and `ts_clr` wins over a load.
- R6: An escape indication (`is_esc`) sampled while bit 2 or bit 3 is 1 makes `trap7` high for exactly the following cycle. With bits 2 and 3 both 0, it leaves `trap7` at 0.
- R7: A wait indication (`is_wait`) makes `trap7` high in the following cycle only when bits 1 and 3 are both 1. Otherwise it leaves `trap7` at 0.
- R8: The trap decision uses the word as it stands before any load or strobe sampled in the same cycle.
- R9: `prot_mode` equals bit 0 of `word_q` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load-word strobe |
| load_data | input | 16 | Word to load (only bits 3:0 are used) |
| ts_set | input | 1 | Set the task-switched bit |
| ts_clr | input | 1 | Clear the task-switched bit |
| is_wait | input | 1 | Decoded wait instruction, one cycle |
| is_esc | input | 1 | Decoded escape instruction, one cycle |
| word_q | output | 16 | Current machine status word |
| prot_mode | output | 1 | Protected mode enabled |
| trap7 | output | 1 | Raise exception 7, one-cycle pulse |

## Verification
On every cycle the assertions check four things:
- the upper twelve bits read as ones, even just after a load that carries zeros there;
- once the protected-enable bit is set, it stays set;
- a set strobe is visible in the next cycle;
- the trap pulse follows escape and wait indications according to the bits that were stored when the indication was sampled.

The bench scenarios are needed to show the rest. These are the exact reset value, the strobe priorities, and that a load in the same cycle as an instruction does not change that instruction's outcome. They also cover every monitor/emulate/task-switched combination for both instruction kinds.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  localparam int WORD_W     = 16;
  localparam int FUNC_BITS  = 4;
  localparam logic [WORD_W-1:0] RESET_WORD = 16'hFFF0;
  localparam int PE_POS = 0;
  localparam int MP_POS = 1;
  localparam int EM_POS = 2;
  localparam int TS_POS = 3;

  typedef struct packed {
    logic ts;
    logic em;
    logic mp;
    logic pe;
  } ctl_bits_t;
endpackage

// File: rtl/mwt_store.sv
module mwt_store
  import mwt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_data,
  input  logic              ts_set,
  input  logic              ts_clr,
  output ctl_bits_t         bits_q,
  output logic [WORD_W-1:0] word
);
  ctl_bits_t bits_d;

  always_comb begin
    bits_d = bits_q;
    if (load_en) begin
      bits_d.mp = load_data[MP_POS];
      bits_d.em = load_data[EM_POS];
      bits_d.ts = load_data[TS_POS];
      bits_d.pe = bits_q.pe | load_data[PE_POS];
    end
    if (ts_clr) bits_d.ts = 1'b0;
    if (ts_set) bits_d.ts = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= ctl_bits_t'(RESET_WORD[FUNC_BITS-1:0]);
    else        bits_q <= bits_d;
  end

  assign word[FUNC_BITS-1:0] = bits_q;
  for (genvar i = FUNC_BITS; i < WORD_W; i++) begin : g_upper
    assign word[i] = RESET_WORD[i];
  end

  assert_pe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word[PE_POS] |=> word[PE_POS]);
  assert_upper_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_data[WORD_W-1:FUNC_BITS] != '1) |=> (word[WORD_W-1:FUNC_BITS] == '1));
  assert_ts_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ts_set |=> word[TS_POS]);
  assert_ts_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_clr && !ts_set) |=> !word[TS_POS]);
endmodule

// File: rtl/mwt_trap.sv
module mwt_trap
  import mwt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctl_bits_t bits,
  input  logic      is_wait,
  input  logic      is_esc,
  output logic      trap7
);
  logic esc_hit, wait_hit;

  assign esc_hit  = is_esc  & (bits.em | bits.ts);
  assign wait_hit = is_wait & bits.mp & bits.ts;

  always_ff @(posedge clk) begin
    if (!rst_n) trap7 <= 1'b0;
    else        trap7 <= esc_hit | wait_hit;
  end

  assert_esc_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_esc && (bits.em || bits.ts)) |=> trap7);
  assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait && !is_esc && !(bits.mp && bits.ts)) |=> !trap7);
  assert_no_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_wait && !is_esc) |=> !trap7);
endmodule

// File: rtl/mode_word_trap.sv
module mode_word_trap
  import mwt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic [15:0] load_data,
  input  logic        ts_set,
  input  logic        ts_clr,
  input  logic        is_wait,
  input  logic        is_esc,
  output logic [15:0] word_q,
  output logic        prot_mode,
  output logic        trap7
);
  ctl_bits_t bits;

  mwt_store u_store (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .ts_set(ts_set), .ts_clr(ts_clr), .bits_q(bits), .word(word_q)
  );

  mwt_trap u_trap (
    .clk(clk), .rst_n(rst_n), .bits(bits),
    .is_wait(is_wait), .is_esc(is_esc), .trap7(trap7)
  );

  assign prot_mode = word_q[PE_POS];

  always_ff @(posedge clk) begin
    if (rst_n) assert_pmode_R9: assert (prot_mode == bits.pe);
  end
endmodule

// File: tb/mode_word_trap_tb.sv
module mode_word_trap_tb;
  logic clk = 0, rst_n = 0;
  logic load_en = 0, ts_set = 0, ts_clr = 0, is_wait = 0, is_esc = 0;
  logic [15:0] load_data = 0;
  logic [15:0] word_q;
  logic prot_mode, trap7;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mode_word_trap u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    load_en = 0; ts_set = 0; ts_clr = 0; is_wait = 0; is_esc = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load(logic [15:0] d);
    load_en = 1; load_data = d; step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 word", word_q, 16'hFFF0);
    chk("R1 pmode", {15'b0, prot_mode}, 16'h0);
    chk("R1 trap", {15'b0, trap7}, 16'h0);
  endtask

  task automatic t_load();
    do_reset();
    load(16'h000E);
    chk("R2 load", word_q, 16'hFFFE);
    chk("R9 pmode off", {15'b0, prot_mode}, 16'h0);
    load(16'h0004);
    chk("R2 reload", word_q, 16'hFFF4);
    load(16'h0000);
    chk("R4 upper ones", word_q, 16'hFFF0);
  endtask

  task automatic t_sticky();
    do_reset();
    load(16'h0001);
    chk("R3 set", word_q, 16'hFFF1);
    chk("R9 pmode on", {15'b0, prot_mode}, 16'h1);
    load(16'h0000);
    chk("R3 sticky", word_q, 16'hFFF1);
    do_reset();
    chk("R3 reset clears", word_q, 16'hFFF0);
  endtask

  task automatic t_ts();
    do_reset();
    ts_set = 1; step();
    chk("R5 set", word_q, 16'hFFF8);
    ts_clr = 1; step();
    chk("R5 clr", word_q, 16'hFFF0);
    ts_set = 1; ts_clr = 1; step();
    chk("R5 set beats clr", word_q, 16'hFFF8);
    load_en = 1; load_data = 16'h000E; ts_clr = 1; step();
    chk("R5 clr beats load", word_q, 16'hFFF6);
  endtask

  task automatic t_esc();
    for (int v = 0; v < 8; v++) begin
      do_reset();
      load(16'(v << 1));
      is_esc = 1; step();
      chk("R6 esc", {15'b0, trap7}, {15'b0, (v[1] | v[2])});
      step();
      chk("R6 pulse ends", {15'b0, trap7}, 16'h0);
    end
  endtask

  task automatic t_wait();
    for (int v = 0; v < 8; v++) begin
      do_reset();
      load(16'(v << 1));
      is_wait = 1; step();
      chk("R7 wait", {15'b0, trap7}, {15'b0, (v[0] & v[2])});
    end
  endtask

  task automatic t_same_cycle();
    do_reset();
    is_esc = 1; load_en = 1; load_data = 16'h0004; step();
    chk("R8 esc old word", {15'b0, trap7}, 16'h0);
    is_esc = 1; load_en = 1; load_data = 16'h0000; step();
    chk("R8 esc before clear", {15'b0, trap7}, 16'h1);
    load(16'h000A);
    is_wait = 1; ts_clr = 1; step();
    chk("R8 wait before clr", {15'b0, trap7}, 16'h1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_load(); t_sticky(); t_ts();
        t_esc(); t_wait(); t_same_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule